// File: doc/BRIEF.md
# Discharge Current Fault Qualifier

This block sits between the synchronized outputs of two discharge-current comparators and the gate drivers of a battery pack's charge and discharge switches. The short-circuit comparator trips at a higher current and the overcurrent comparator at a lower one. Each indication must hold without a break for its own programmable number of clock cycles before it counts. A qualified fault turns the discharge switch off, and the switch stays off until software or a supervisor pulses the clear input while that condition is gone.

Two other inputs also gate the switches. A configuration-fault bit reports that the overcurrent delay setting is unusable, and while it is high both switch enables are forced off. A wake pulse, and also reset, starts a fixed settle interval. Both enables stay off until that interval has run out and the configuration is valid. A two-bit status code reports which current fault is latched, and the short circuit wins when both are latched.

Top module: `dcq_top`

## Requirements
- R1: While reset is high, and on the first edge after it, `chg_en` and `dsg_en` are 0 and `fault_code` is 2'b00. Reset also starts the settle interval of R8.
- R2: `dsg_en` falls, and `fault_code` becomes 2'b10, on the clock edge that samples `sc_flag` high for the `sc_delay`-th consecutive time.
- R3: A drop of a current condition for one sampled cycle before its delay is reached cancels it. The persistence count restarts from zero, so a later run needs the full delay again.
- R4: The overcurrent condition qualifies by the same rule against `oc_delay`, independently of the short-circuit count. It drives `fault_code` to 2'b01 when no short circuit is latched.
- R5: A latched current fault keeps `dsg_en` at 0 until an edge samples `fault_clr` high while that condition is low. A `fault_clr` sampled while the condition is still high has no effect.
- R6: `fault_code` encodes 2'b10 for a latched short circuit, 2'b01 for a latched overcurrent only, and 2'b00 for none. It is never 2'b11, and the short circuit takes priority, including when both qualify on the same edge.
- R7: One edge after `cfg_bad` is sampled high, both enables are 0. They stay 0 for as long as it stays high.
- R8: After an edge samples `wake` high, both enables are 0 for exactly SETTLE_CYC edges. They may rise on the SETTLE_CYC-th edge after it.
- R9: A delay value of 0 qualifies a condition on the first edge that samples it high, the same as a delay of 1.
- R10: `chg_en` is unaffected by current faults. `dsg_en` is 1 only when `chg_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_flag | input | 1 | Synchronized short-circuit comparator output |
| oc_flag | input | 1 | Synchronized overcurrent comparator output |
| sc_delay | input | DLY_W | Short-circuit persistence delay in cycles |
| oc_delay | input | DLY_W | Overcurrent persistence delay in cycles |
| cfg_bad | input | 1 | Delay configuration invalid |
| wake | input | 1 | Wake-from-sleep pulse |
| fault_clr | input | 1 | Clear request for latched current faults |
| chg_en | output | 1 | Charge switch enable, active high |
| dsg_en | output | 1 | Discharge switch enable, active high |
| fault_code | output | 2 | Latched current fault status |

## Verification
The bench builds the block with DLY_W=8 and SETTLE_CYC=20. This keeps the whole settle window short enough to time edge by edge, and it lets delays from 0 to a dozen cycles be driven. A run that stops just short of its delay and one that lands exactly on it can therefore be compared side by side. The short delays also make it practical to line up both qualifiers on the same edge, which exercises the priority rule, and to overlap a wake, a configuration fault and a latched fault within a single random run.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_OVER  = 2'b01,
    FC_SHORT = 2'b10
  } fcode_e;
endpackage

// File: rtl/dcq_persist.sv
// One persistence qualifier: counts consecutive cycles of a condition,
// saturates at the programmed delay and latches a fault until cleared.
module dcq_persist #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cond,
  input  logic [DLY_W-1:0] delay,
  input  logic             clr,
  output logic             lat_d
);
  localparam int CW = DLY_W + 1;

  logic [DLY_W-1:0] cnt_q;
  logic             lat_q;
  logic             hit;

  // qualifies on the cycle where this sample completes the run
  assign hit = cond && (({1'b0, cnt_q} + CW'(1)) >= {1'b0, delay});

  always_comb begin
    if (hit)
      lat_d = 1'b1;
    else if (clr && !cond)
      lat_d = 1'b0;
    else
      lat_d = lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else begin
      if (!cond)
        cnt_q <= '0;
      else if (cnt_q < delay)
        cnt_q <= cnt_q + DLY_W'(1);
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/dcq_settle.sv
// Settle timer started by reset or a wake pulse.
module dcq_settle #(
  parameter int SETTLE_CYC = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  output logic busy_d
);
  localparam int ST_W = $clog2(SETTLE_CYC + 2);

  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;

  always_comb begin
    if (wake)
      st_d = ST_W'(SETTLE_CYC);
    else if (st_q != '0)
      st_d = st_q - ST_W'(1);
    else
      st_d = '0;
  end

  assign busy_d = (st_d != '0);

  always_ff @(posedge clk) begin
    if (rst)
      st_q <= ST_W'(SETTLE_CYC);
    else
      st_q <= st_d;
  end
endmodule

// File: rtl/dcq_top.sv
module dcq_top #(
  parameter int DLY_W      = 16,
  parameter int SETTLE_CYC = 1600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sc_flag,
  input  logic             oc_flag,
  input  logic [DLY_W-1:0] sc_delay,
  input  logic [DLY_W-1:0] oc_delay,
  input  logic             cfg_bad,
  input  logic             wake,
  input  logic             fault_clr,
  output logic             chg_en,
  output logic             dsg_en,
  output logic [1:0]       fault_code
);
  import dcq_pkg::*;

  localparam int NCH   = 2;
  localparam int CH_SC = 0;
  localparam int CH_OC = 1;

  logic [NCH-1:0]   cond_v;
  logic [DLY_W-1:0] dly_v [NCH];
  logic [NCH-1:0]   lat_d;
  logic             settle_d;
  logic             hold_d;
  fcode_e           code_d;

  assign cond_v[CH_SC] = sc_flag;
  assign cond_v[CH_OC] = oc_flag;
  assign dly_v[CH_SC]  = sc_delay;
  assign dly_v[CH_OC]  = oc_delay;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      dcq_persist #(.DLY_W(DLY_W)) u_q (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond_v[g]),
        .delay (dly_v[g]),
        .clr   (fault_clr),
        .lat_d (lat_d[g])
      );
    end
  endgenerate

  dcq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .wake   (wake),
    .busy_d (settle_d)
  );

  assign hold_d = settle_d | cfg_bad;

  always_comb begin
    if (lat_d[CH_SC])
      code_d = FC_SHORT;
    else if (lat_d[CH_OC])
      code_d = FC_OVER;
    else
      code_d = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en     <= 1'b0;
      dsg_en     <= 1'b0;
      fault_code <= FC_NONE;
    end else begin
      chg_en     <= !hold_d;
      dsg_en     <= !hold_d && (lat_d == '0);
      fault_code <= code_d;
    end
  end
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker (
  input logic       clk,
  input logic       rst,
  input logic       sc_flag,
  input logic       cfg_bad,
  input logic       wake,
  input logic       fault_clr,
  input logic       chg_en,
  input logic       dsg_en,
  input logic [1:0] fault_code
);
  // R7
  p_cfg_off_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> (!chg_en && !dsg_en));
  // R8
  p_wake_off_r8: assert property (@(posedge clk) disable iff (rst)
    wake |=> (!chg_en && !dsg_en));
  // R10
  p_dsg_needs_chg_r10: assert property (@(posedge clk) disable iff (rst)
    dsg_en |-> chg_en);
  // R5
  p_fault_blocks_dsg_r5: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 2'b00) |-> !dsg_en);
  // R6
  p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    fault_code != 2'b11);
  // R2
  p_short_needs_flag_r2: assert property (@(posedge clk) disable iff (rst)
    ((fault_code == 2'b10) && ($past(fault_code) != 2'b10)) |-> $past(sc_flag));
  // R5
  p_clear_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    ((fault_code == 2'b00) && ($past(fault_code) != 2'b00)) |-> $past(fault_clr));
endmodule

bind dcq_top dcq_checker u_dcq_chk (
  .clk        (clk),
  .rst        (rst),
  .sc_flag    (sc_flag),
  .cfg_bad    (cfg_bad),
  .wake       (wake),
  .fault_clr  (fault_clr),
  .chg_en     (chg_en),
  .dsg_en     (dsg_en),
  .fault_code (fault_code)
);

// File: tb/tb_dcq_top.sv
module tb_dcq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int SET = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sc_flag = 1'b0, oc_flag = 1'b0;
  logic [DW-1:0] sc_delay = 8'd6, oc_delay = 8'd12;
  logic cfg_bad = 1'b0, wake = 1'b0, fault_clr = 1'b0;
  logic chg_en, dsg_en;
  logic [1:0] fault_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int sc_run = 0, oc_run = 0, settle = SET;
  bit sc_l = 0, oc_l = 0;
  bit e_chg = 0, e_dsg = 0;
  int e_code = 0;

  dcq_top #(.DLY_W(DW), .SETTLE_CYC(SET)) dut (
    .clk(clk), .rst(rst), .sc_flag(sc_flag), .oc_flag(oc_flag),
    .sc_delay(sc_delay), .oc_delay(oc_delay), .cfg_bad(cfg_bad),
    .wake(wake), .fault_clr(fault_clr), .chg_en(chg_en),
    .dsg_en(dsg_en), .fault_code(fault_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit sh, oh;
    started = 1;
    if (rst) begin
      sc_run = 0; oc_run = 0; sc_l = 0; oc_l = 0; settle = SET;
    end else begin
      sh = sc_flag && (sc_run + 1 >= int'(sc_delay));
      oh = oc_flag && (oc_run + 1 >= int'(oc_delay));
      if (!sc_flag) sc_run = 0; else if (sc_run < int'(sc_delay)) sc_run++;
      if (!oc_flag) oc_run = 0; else if (oc_run < int'(oc_delay)) oc_run++;
      if (sh) sc_l = 1; else if (fault_clr && !sc_flag) sc_l = 0;
      if (oh) oc_l = 1; else if (fault_clr && !oc_flag) oc_l = 0;
      if (wake) settle = SET; else if (settle > 0) settle--;
    end
    e_chg  = !rst && !cfg_bad && (settle != 0 ? 1'b0 : 1'b1);
    e_dsg  = e_chg && !sc_l && !oc_l;
    e_code = rst ? 0 : (sc_l ? 2 : (oc_l ? 1 : 0));
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (chg_en !== e_chg || dsg_en !== e_dsg || fault_code !== 2'(e_code)) begin
        failures++;
        $display("FAIL model R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 t=%0t actual chg=%b dsg=%b code=%0d expected chg=%b dsg=%b code=%0d",
                 $time, chg_en, dsg_en, fault_code, e_chg, e_dsg, e_code);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R1 actual cycles=%0d expected below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expect_out(string tag, logic c, logic d, logic [1:0] k);
    checks++;
    if (chg_en !== c || dsg_en !== d || fault_code !== k) begin
      failures++;
      $display("FAIL %s actual chg=%b dsg=%b code=%0d expected chg=%b dsg=%b code=%0d",
               tag, chg_en, dsg_en, fault_code, c, d, k);
    end
  endtask

  initial begin
    tick(3);
    expect_out("R1 reset", 1'b0, 1'b0, 2'b00);
    rst = 1'b0;
    tick(1);
    expect_out("R1 first edge after reset", 1'b0, 1'b0, 2'b00);
    tick(SET + 2);
    expect_out("R8 settle done after reset", 1'b1, 1'b1, 2'b00);

    // R3: short run then restart
    sc_flag = 1'b1; tick(5); sc_flag = 1'b0; tick(1);
    expect_out("R3 short run cancelled", 1'b1, 1'b1, 2'b00);
    sc_flag = 1'b1; tick(5);
    expect_out("R3 count restarted from zero", 1'b1, 1'b1, 2'b00);
    tick(1);
    expect_out("R2 short qualifies on 6th edge", 1'b1, 1'b0, 2'b10);

    // R5: clear ignored while condition present
    fault_clr = 1'b1; tick(1);
    expect_out("R5 clear ignored while short present", 1'b1, 1'b0, 2'b10);
    sc_flag = 1'b0; fault_clr = 1'b0; tick(3);
    expect_out("R5 latched without clear", 1'b1, 1'b0, 2'b10);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    expect_out("R5 cleared", 1'b1, 1'b1, 2'b00);

    // R4 and R10: overcurrent alone
    oc_flag = 1'b1; tick(11);
    expect_out("R4 overcurrent not yet", 1'b1, 1'b1, 2'b00);
    tick(1);
    expect_out("R4 overcurrent qualifies R10 charge kept", 1'b1, 1'b0, 2'b01);

    // R6: short over latched overcurrent
    sc_flag = 1'b1; tick(6);
    expect_out("R6 short overrides overcurrent", 1'b1, 1'b0, 2'b10);
    sc_flag = 1'b0; oc_flag = 1'b0; fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    expect_out("R5 both cleared", 1'b1, 1'b1, 2'b00);

    // R6: simultaneous qualification
    sc_delay = 8'd5; oc_delay = 8'd5;
    sc_flag = 1'b1; oc_flag = 1'b1; tick(5);
    expect_out("R6 same-edge priority", 1'b1, 1'b0, 2'b10);
    sc_flag = 1'b0; tick(1);
    expect_out("R6 short latched, overcurrent still present", 1'b1, 1'b0, 2'b10);
    oc_flag = 1'b0; fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    expect_out("R5 cleared again", 1'b1, 1'b1, 2'b00);

    // R9: zero delay
    sc_delay = 8'd0; sc_flag = 1'b1; tick(1); sc_flag = 1'b0;
    expect_out("R9 zero delay immediate", 1'b1, 1'b0, 2'b10);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    sc_delay = 8'd6; oc_delay = 8'd12;

    // R7
    cfg_bad = 1'b1; tick(1);
    expect_out("R7 cfg fault forces off", 1'b0, 1'b0, 2'b00);
    tick(3);
    expect_out("R7 cfg fault held", 1'b0, 1'b0, 2'b00);
    cfg_bad = 1'b0; tick(1);
    expect_out("R7 cfg fault released", 1'b1, 1'b1, 2'b00);

    // R8
    wake = 1'b1; tick(1); wake = 1'b0;
    expect_out("R8 wake forces off", 1'b0, 1'b0, 2'b00);
    tick(SET - 1);
    expect_out("R8 still settling", 1'b0, 1'b0, 2'b00);
    tick(1);
    expect_out("R8 settle complete", 1'b1, 1'b1, 2'b00);

    // mixed random traffic, compared every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      sc_flag   = ($urandom_range(0, 9) < 6) ? sc_flag : ~sc_flag;
      oc_flag   = ($urandom_range(0, 9) < 7) ? oc_flag : ~oc_flag;
      fault_clr = ($urandom_range(0, 19) == 0);
      cfg_bad   = ($urandom_range(0, 99) < 3);
      wake      = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 49) == 0) sc_delay = 8'($urandom_range(0, 8));
      if ($urandom_range(0, 49) == 0) oc_delay = 8'($urandom_range(0, 12));
      tick(1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule